// File: doc/BRIEF.md
# Integrating Vertical Sync Detector

This block finds the vertical blanking interval in a sampled, active-low composite sync stream and produces an active-low vertical pulse. It is clocked by a sample clock, and every timing value is given as a count of sample cycles. An up/down integrator follows the sync input: it climbs one step for every sample in which sync is low and falls one step for every sample in which it is high, and it clamps at both ends. The wide low pulses of the vertical interval push the integrator over a threshold. Normal line sync pulses and half-line equalizing pulses never reach it.

Once the integrator has crossed the threshold, the vertical output is started by the next rising sync edge, which is the serration that ends the first wide pulse. It is ended by a later rising edge. The first post-equalizing pulse ends with the integrator below the threshold, and the output stops on the rising edge of the second such pulse. Both ends of the pulse are tied to sync edges, so the pulse width is fixed for standard signals at three lines plus one serration plus one equalizing pulse. Some signals hold sync low through the whole interval with no serrations. For these, a fallback timer starts the output a fixed number of cycles after the threshold is crossed. The end condition does not change.

Top module: `vsync_integrating_det`

## Requirements
- R1: While reset is held and directly after it, `vsync_n` is high and the integrator is empty.
- R2: The integrator steps up by one for each synchronized low sample and down by one for each high sample. It clamps at 0 and at `INTEG_MAX`, so a long high stretch does not wrap it and a long low stretch does not delay recovery.
- R3: With an empty integrator, an isolated low pulse of `INTEG_THRESH - 1` samples never starts the output. A pulse of exactly `INTEG_THRESH` samples starts it.
- R4: `vsync_n` falls `SYNC_STAGES + 1` cycles after the first rising sync edge at which the integrator is at or above `INTEG_THRESH` (the serration). The wide pulses that follow it do not start a second pulse.
- R5: While the output is active, the first rising edge that finds the integrator below `INTEG_THRESH` counts as post-equalizing edge 1. `vsync_n` rises `SYNC_STAGES + 1` cycles after post-equalizing edge `POST_EQ_EDGES`, and it stays low until then.
- R6: If sync stays low with no serration, `vsync_n` falls `SYNC_STAGES + 1 + INTEG_THRESH + FALLBACK_CYC` cycles after the low level is driven, starting from an empty integrator.
- R7: Normal line sync pulses and half-line equalizing pulses never assert `vsync_n`.
- R8: For a standard interval the low width equals 3 lines + one serration + one equalizing low time, counted in input cycles.
- R9: An extra pre-equalizing pulse ahead of the interval does not move the start of the output or change how many pulses are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_n | input | 1 | Composite sync, active low, asynchronous to clk |
| vsync_n | output | 1 | Vertical output, active low, registered |

## Verification
A wrong integrator count or threshold test shows up as a vertical pulse that starts one wide pulse late, or one whose end slips by a whole half-line. It can also show as a spurious pulse during equalizing. Every such error is visible at `vsync_n` within one half-line of the faulty edge. Each edge of the output is therefore compared to the exact cycle of the input edge that should cause it. A broken clamp shows only after a long stretch: a wrapped floor falsely asserts on the next short pulse, and a missing ceiling makes the output end a pulse or more late after a serration-free interval.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  typedef enum logic [1:0] {
    VS_IDLE   = 2'd0,
    VS_ARMED  = 2'd1,
    VS_ACTIVE = 2'd2,
    VS_TRAIL  = 2'd3
  } vs_state_e;

  // Saturating up/down step of the integrator.
  function automatic int integ_next(input int cnt, input logic low, input int cmax);
    if (low) return (cnt >= cmax) ? cmax : cnt + 1;
    return (cnt <= 0) ? 0 : cnt - 1;
  endfunction

  // True when the edge being seen completes the post-equalizing count.
  function automatic logic post_eq_done(input int seen_before, input int need);
    return (seen_before + 1) >= need;
  endfunction

  // States in which the vertical output is driven low.
  function automatic logic drives_low(input vs_state_e st);
    return (st == VS_ACTIVE) || (st == VS_TRAIL);
  endfunction

endpackage

// File: rtl/vsd_sync_edge.sv
module vsd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain;

  for (genvar i = 0; i < CHAIN; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/vsd_integrator.sv
module vsd_integrator import vsd_pkg::*; #(
  parameter int INTEG_MAX    = 34,
  parameter int INTEG_THRESH = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             sync_lvl,
  input  logic                             rise,
  output logic [$clog2(INTEG_MAX+1)-1:0]   cnt,
  output logic                             over,
  output logic                             flag
);
  localparam int CW = $clog2(INTEG_MAX + 1);
  localparam logic [CW-1:0] THR = CW'(INTEG_THRESH);

  logic [CW-1:0] cnt_d;

  always_comb cnt_d = CW'(integ_next(int'(cnt), ~sync_lvl, INTEG_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign over = (cnt >= THR);

  // Vertical flag: set on crossing, cleared only by a rising edge that
  // finds the integrator short of the threshold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag <= 1'b0;
    else if (over)       flag <= 1'b1;
    else if (rise)       flag <= 1'b0;
  end

endmodule

// File: rtl/vsd_sequencer.sv
module vsd_sequencer import vsd_pkg::*; #(
  parameter int FALLBACK_CYC  = 131,
  parameter int POST_EQ_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic over,
  output logic vsync_n,
  output logic tmr_done
);
  localparam int TW = $clog2(FALLBACK_CYC + 1);
  localparam int PW = $clog2(POST_EQ_EDGES + 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(FALLBACK_CYC - 1);

  vs_state_e     st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  assign tmr_done = (st_q == VS_ARMED) && (tmr_q == TMR_LAST);

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    pcnt_d = pcnt_q;
    unique case (st_q)
      VS_IDLE: begin
        tmr_d  = '0;
        pcnt_d = '0;
        if (over) st_d = rise ? VS_ACTIVE : VS_ARMED;
      end
      VS_ARMED: begin
        if (rise || tmr_done) st_d = VS_ACTIVE;
        else                  tmr_d = tmr_q + TW'(1);
      end
      VS_ACTIVE: begin
        if (rise && !over) begin
          if (post_eq_done(0, POST_EQ_EDGES)) st_d = VS_IDLE;
          else begin
            st_d   = VS_TRAIL;
            pcnt_d = PW'(1);
          end
        end
      end
      VS_TRAIL: begin
        if (rise) begin
          if (post_eq_done(int'(pcnt_q), POST_EQ_EDGES)) st_d = VS_IDLE;
          else pcnt_d = pcnt_q + PW'(1);
        end
      end
      default: st_d = VS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= VS_IDLE;
      tmr_q   <= '0;
      pcnt_q  <= '0;
      vsync_n <= 1'b1;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      pcnt_q  <= pcnt_d;
      vsync_n <= ~drives_low(st_d);
    end
  end

endmodule

// File: rtl/vsync_integrating_det.sv
module vsync_integrating_det #(
  parameter int SYNC_STAGES   = 2,
  parameter int INTEG_MAX     = 34,
  parameter int INTEG_THRESH  = 32,
  parameter int FALLBACK_CYC  = 131,
  parameter int POST_EQ_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  output logic vsync_n
);
  localparam int CW = $clog2(INTEG_MAX + 1);

  // Internal events, named for the bound checker.
  logic          lvl_w;
  logic          rise_w;
  logic [CW-1:0] integ_cnt_w;
  logic          over_w;
  logic          flag_w;
  logic          tmr_done_w;

  vsd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (csync_n),
    .level (lvl_w),
    .rise  (rise_w)
  );

  vsd_integrator #(.INTEG_MAX(INTEG_MAX), .INTEG_THRESH(INTEG_THRESH)) u_integ (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_lvl (lvl_w),
    .rise     (rise_w),
    .cnt      (integ_cnt_w),
    .over     (over_w),
    .flag     (flag_w)
  );

  vsd_sequencer #(.FALLBACK_CYC(FALLBACK_CYC), .POST_EQ_EDGES(POST_EQ_EDGES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise_w),
    .over     (over_w),
    .vsync_n  (vsync_n),
    .tmr_done (tmr_done_w)
  );

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
  parameter int INTEG_MAX = 34,
  parameter int CW        = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vsync_n,
  input logic          rise,
  input logic          over,
  input logic          flag,
  input logic          tmr_done,
  input logic [CW-1:0] cnt
);

  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= INTEG_MAX);

  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> ((int'(cnt) == int'($past(cnt)) + 1) || (int'(cnt) + 1 == int'($past(cnt)))));

  a_r3_flag_needs_charge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(over));

  a_r4_start_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $past((rise && over) || tmr_done));

  a_r5_flag_clear_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(rise && !over));

  a_r5_end_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> $past(rise && !over));

  a_r6_timer_while_charged: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |-> over);

endmodule

bind vsync_integrating_det vsd_checker #(
  .INTEG_MAX (INTEG_MAX),
  .CW        ($clog2(INTEG_MAX + 1))
) u_vsd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .vsync_n  (vsync_n),
  .rise     (rise_w),
  .over     (over_w),
  .flag     (flag_w),
  .tmr_done (tmr_done_w),
  .cnt      (integ_cnt_w)
);

// File: tb/test_vsync_integrating_det.sv
`timescale 1ns/1ps
module test_vsync_integrating_det;
  localparam int THRESH = 32;
  localparam int FB     = 131;
  localparam int LAT    = 3;     // two sync stages + one state register
  localparam int H      = 128;   // samples per line in the stimulus
  localparam int SERR   = 10;
  localparam int EQ_LO  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_n = 1'b1;
  logic vsync_n;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int fall_cyc = -1;
  int rise_cyc = -1;
  int n_falls = 0;
  logic vs_prev = 1'b1;
  bit done = 1'b0;

  vsync_integrating_det i_vsync_integrating_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .csync_n (csync_n),
    .vsync_n (vsync_n)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (vs_prev === 1'b1 && vsync_n === 1'b0) begin
      fall_cyc = cyc;
      n_falls++;
    end
    if (vs_prev === 1'b0 && vsync_n === 1'b1) rise_cyc = cyc;
    vs_prev = vsync_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called and returns at a falling clock edge.
  task automatic pulse(input int lo, input int hi, output int r);
    csync_n = 1'b0;
    repeat (lo) @(negedge clk);
    csync_n = 1'b1;
    r = cyc;
    repeat (hi) @(negedge clk);
  endtask

  task automatic lines(input int n);
    int r;
    for (int i = 0; i < n; i++) pulse(SERR, H - SERR, r);
  endtask

  task automatic eq_pulses(input int n);
    int r;
    for (int i = 0; i < n; i++) pulse(EQ_LO, H/2 - EQ_LO, r);
  endtask

  task automatic t_reset();
    check(vsync_n === 1'b1, "R1 idle after reset", int'(vsync_n), 1);
  endtask

  task automatic t_plain();
    int f0 = n_falls;
    lines(6);
    eq_pulses(12);
    lines(3);
    check(n_falls == f0, "R7 no pulse from line/equalizing sync", n_falls - f0, 0);
    check(vsync_n === 1'b1, "R7 output idle", int'(vsync_n), 1);
  endtask

  task automatic t_standard(input int extra_pre);
    int f0 = n_falls;
    int r, rs, p2;
    lines(2);
    eq_pulses(6 + extra_pre);
    pulse(H/2 - SERR, SERR, rs);
    check(vsync_n === 1'b0, "R4 low after first serration", int'(vsync_n), 0);
    for (int i = 0; i < 5; i++) pulse(H/2 - SERR, SERR, r);
    pulse(EQ_LO, H/2 - EQ_LO, r);
    check(vsync_n === 1'b0, "R5 held through first post-eq", int'(vsync_n), 0);
    pulse(EQ_LO, H/2 - EQ_LO, p2);
    eq_pulses(4);
    lines(2);
    check(n_falls - f0 == 1, extra_pre > 0 ? "R9 single pulse" : "R4 single pulse", n_falls - f0, 1);
    check(fall_cyc == rs + LAT, extra_pre > 0 ? "R9 start cycle" : "R4 start cycle", fall_cyc, rs + LAT);
    check(rise_cyc == p2 + LAT, "R5 end cycle", rise_cyc, p2 + LAT);
    check(rise_cyc - fall_cyc == 3*H + SERR + EQ_LO, "R8 width", rise_cyc - fall_cyc, 3*H + SERR + EQ_LO);
  endtask

  task automatic t_threshold();
    int f0, r, p2;
    pulse(10, 300, r);
    f0 = n_falls;
    pulse(THRESH - 1, 200, r);
    check(n_falls == f0, "R3 short pulse ignored (R2 floor)", n_falls - f0, 0);
    check(vsync_n === 1'b1, "R3 output idle", int'(vsync_n), 1);
    pulse(THRESH, 200, r);
    check(n_falls == f0 + 1, "R3 threshold pulse starts", n_falls - f0, 1);
    check(fall_cyc == r + LAT, "R3 start cycle", fall_cyc, r + LAT);
    pulse(EQ_LO, H/2 - EQ_LO, r);
    check(vsync_n === 1'b0, "R5 held after flag clears", int'(vsync_n), 0);
    pulse(EQ_LO, H/2 - EQ_LO, p2);
    check(rise_cyc == p2 + LAT, "R5 end cycle", rise_cyc, p2 + LAT);
  endtask

  task automatic t_fallback();
    int l, r, p2;
    int f0;
    lines(2);
    eq_pulses(6);
    f0 = n_falls;
    l = cyc;
    pulse(370, SERR, r);
    check(n_falls == f0 + 1, "R6 one pulse", n_falls - f0, 1);
    check(fall_cyc == l + LAT + THRESH + FB, "R6 fallback start", fall_cyc, l + LAT + THRESH + FB);
    pulse(EQ_LO, H/2 - EQ_LO, r);
    pulse(EQ_LO, H/2 - EQ_LO, p2);
    eq_pulses(4);
    check(rise_cyc == p2 + LAT, "R2 ceiling lets post-eq end on time", rise_cyc, p2 + LAT);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(vsync_n === 1'b1, "R1 high in reset", int'(vsync_n), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain();
    t_standard(0);
    t_standard(1);
    t_threshold();
    t_fallback();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule